// File: doc/BRIEF.md
# Ring Node Packet Forwarder

This block is one stop on a one-way, point-to-point memory ring. Each cycle it takes in a byte-wide bus and two strobes from the node before it, and drives all three out to the node after it one clock later. One strobe marks command packets and the other marks data packets. Because every node regenerates every signal, each output drives only the next node.

The node does not use chip-enable pins. It watches command packets instead. The first byte of a packet is a device ID, which is compared against the node's configured ID and against an all-ones broadcast value. The second byte is the opcode. When an accepted packet carries the burst-read opcode, the node arms itself. During the next data-strobe window it replaces the forwarded bus bytes with bytes from a local read source, one byte per cycle. The two strobes always pass through unchanged.

An active-low enable suspends the node for standby. An active-low reset clears the node and holds every output low.

Top module: `ring_node`

## Requirements
- R1: While `rst_n` is low, `bus_out`, `cmd_out`, `dat_out` and `rd_take` are all 0. The reset also cancels a pending read, so a data window that follows reset is forwarded unchanged.
- R2: When the node is not substituting, `bus_out`, `cmd_out` and `dat_out` equal `bus_in`, `cmd_in` and `dat_in` from exactly one clock earlier. Command bytes are forwarded like any other bytes.
- R3: `cmd_out` and `dat_out` are never altered, including during substitution.
- R4: The first byte of a command window (the first cycle with `cmd_in` high) is the device ID and the second byte is the opcode. A packet is accepted when its ID equals `cfg_id` or equals 0xFF (broadcast).
- R5: After an accepted packet with opcode 0x30 (burst read), each cycle of the next window in which `dat_in` is high makes `bus_out` carry `rd_data` one cycle later, and `rd_take` is high in that cycle so that the source advances.
- R6: If `rd_avail` is low during a substituted cycle, 0x00 is driven and `rd_take` stays low.
- R7: A packet whose ID is neither `cfg_id` nor 0xFF causes no substitution.
- R8: The read window closes when `dat_in` falls, and later data windows are forwarded unchanged.
- R9: While `en_n` is high, all outputs hold their values, `rd_take` is 0 and bus input is ignored.
- R10: An accepted packet with an opcode other than 0x30 does not arm a read, and it cancels a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Active-low reset |
| en_n | input | 1 | Active-low enable; high suspends the node |
| cfg_id | input | 8 | This node's device ID |
| bus_in | input | 8 | Bus byte from the previous node |
| cmd_in | input | 1 | Command strobe in |
| dat_in | input | 1 | Data strobe in |
| rd_data | input | 8 | Current byte from the local read source |
| rd_avail | input | 1 | Read source has a byte |
| rd_take | output | 1 | Read source byte consumed this cycle |
| bus_out | output | 8 | Bus byte to the next node |
| cmd_out | output | 1 | Command strobe out |
| dat_out | output | 1 | Data strobe out |

## Verification
Every forwarded or substituted output is due exactly one rising edge after the inputs that caused it. The exception is `rd_take`, which is combinational in the same cycle as the data strobe. The driver applies inputs on the falling edge and queues the expected outputs. The monitor pops and compares them just after the next rising edge, so each comparison lines up with the one-register latency. For suspended cycles the expected value is the previous output. The number of read bytes consumed is checked against the number of substituted cycles that had a byte available.

// File: rtl/ring_node.sv
module ring_node #(
  parameter int W = 8,
  parameter logic [W-1:0] RD_OP = 8'h30,
  parameter logic [W-1:0] BCAST = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic [W-1:0] cfg_id,
  input  logic [W-1:0] bus_in,
  input  logic         cmd_in,
  input  logic         dat_in,
  input  logic [W-1:0] rd_data,
  input  logic         rd_avail,
  output logic         rd_take,
  output logic [W-1:0] bus_out,
  output logic         cmd_out,
  output logic         dat_out
);

  typedef enum logic [1:0] {P_ID, P_OP, P_BODY} phase_t;

  phase_t phase;
  logic   id_ok;
  logic   armed;
  logic   sub;
  logic   run;

  assign run     = ~en_n;
  assign sub     = armed & dat_in;
  assign rd_take = sub & rd_avail & run & rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_out <= '0;
      cmd_out <= 1'b0;
      dat_out <= 1'b0;
    end else if (run) begin
      cmd_out <= cmd_in;
      dat_out <= dat_in;
      if (sub) bus_out <= rd_avail ? rd_data : '0;
      else     bus_out <= bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_ID;
      id_ok <= 1'b0;
      armed <= 1'b0;
    end else if (run) begin
      if (armed && dat_out && !dat_in) armed <= 1'b0;
      if (!cmd_in) begin
        phase <= P_ID;
      end else begin
        case (phase)
          P_ID: begin
            id_ok <= (bus_in == cfg_id) || (bus_in == BCAST);
            phase <= P_OP;
          end
          P_OP: begin
            if (id_ok) armed <= (bus_in == RD_OP);
            phase <= P_BODY;
          end
          default: phase <= P_BODY;
        endcase
      end
    end
  end

endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_n,
  input logic [W-1:0] bus_in,
  input logic         cmd_in,
  input logic         dat_in,
  input logic [W-1:0] rd_data,
  input logic         rd_avail,
  input logic         rd_take,
  input logic [W-1:0] bus_out,
  input logic         cmd_out,
  input logic         dat_out
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  always @(negedge clk)
    if (!rst_n)
      assert_reset_low_R1: assert (bus_out == '0 && !cmd_out && !dat_out && !rd_take);

  assert_cmd_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(!en_n) |-> cmd_out == $past(cmd_in));

  assert_dat_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(!en_n) |-> dat_out == $past(dat_in));

  assert_bus_only_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(!en_n) && !$past(dat_in) |-> bus_out == $past(bus_in));

  assert_take_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(rd_take) |-> bus_out == $past(rd_data));

  assert_take_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> rd_avail && dat_in);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(en_n) |-> $stable(bus_out) && $stable(cmd_out) && $stable(dat_out));

  assert_no_take_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !rd_take);

endmodule

bind ring_node ring_node_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .bus_in(bus_in), .cmd_in(cmd_in),
  .dat_in(dat_in), .rd_data(rd_data), .rd_avail(rd_avail), .rd_take(rd_take),
  .bus_out(bus_out), .cmd_out(cmd_out), .dat_out(dat_out)
);

// File: tb/ring_node_bench.sv
module ring_node_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_n = 1'b0;
  logic [7:0] cfg_id = 8'h5A;
  logic [7:0] bus_in = '0;
  logic       cmd_in = 1'b0;
  logic       dat_in = 1'b0;
  logic [7:0] rd_data;
  logic       rd_avail;
  logic       rd_take;
  logic [7:0] bus_out;
  logic       cmd_out;
  logic       dat_out;

  always #5 clk = ~clk;

  ring_node u_ring_node (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .cfg_id(cfg_id), .bus_in(bus_in),
    .cmd_in(cmd_in), .dat_in(dat_in), .rd_data(rd_data), .rd_avail(rd_avail),
    .rd_take(rd_take), .bus_out(bus_out), .cmd_out(cmd_out), .dat_out(dat_out)
  );

  typedef struct packed { logic [7:0] b; logic c; logic d; logic [7:0] tag; } exp_t;

  exp_t       sb[$];
  logic [7:0] exp_rd[$];
  logic [7:0] src_mem [0:15];
  int         src_cnt = 0;
  int         src_ptr = 0;
  int         takes = 0;
  int         exp_takes = 0;
  int         checks = 0;
  int         errors = 0;
  exp_t       last = '0;

  assign rd_avail = src_ptr < src_cnt;
  assign rd_data  = rd_avail ? src_mem[src_ptr[3:0]] : 8'h00;

  always @(posedge clk) if (rd_take) begin src_ptr <= src_ptr + 1; takes <= takes + 1; end

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (bus_out !== e.b || cmd_out !== e.c || dat_out !== e.d) begin
        errors++;
        $display("FAIL R%0d: got bus=%h cmd=%b dat=%b expected bus=%h cmd=%b dat=%b",
                 e.tag, bus_out, cmd_out, dat_out, e.b, e.c, e.d);
      end
    end
  end

  task automatic load_src(input int n, input logic [7:0] base);
    src_cnt = 0; src_ptr = 0;
    exp_rd.delete();
    for (int i = 0; i < n; i++) begin
      src_mem[i] = base + 8'(i);
      exp_rd.push_back(base + 8'(i));
      src_cnt++;
    end
  endtask

  task automatic step(input logic [7:0] b, input logic c, input logic d,
                      input logic hold, input logic sub, input logic [7:0] tag);
    exp_t e;
    @(negedge clk);
    bus_in = b; cmd_in = c; dat_in = d; en_n = hold;
    if (hold) e = last;
    else begin
      e.c = c; e.d = d; e.b = b;
      if (sub) begin
        if (exp_rd.size() > 0) begin e.b = exp_rd.pop_front(); exp_takes++; end
        else e.b = 8'h00;
      end
    end
    e.tag = tag;
    last = e;
    sb.push_back(e);
  endtask

  task automatic command(input logic [7:0] id, input logic [7:0] op, input logic [7:0] tag);
    step(id, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    step(op, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    step(8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic window(input int n, input logic sub, input logic [7:0] tag);
    for (int i = 0; i < n; i++) step(8'hE0 + 8'(i), 1'b0, 1'b1, 1'b0, sub, tag);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_in = 8'hA5; cmd_in = 1'b1; dat_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (bus_out !== 8'h00 || cmd_out !== 1'b0 || dat_out !== 1'b0 || rd_take !== 1'b0) begin
      errors++;
      $display("FAIL R1: got bus=%h cmd=%b dat=%b take=%b expected all zero",
               bus_out, cmd_out, dat_out, rd_take);
    end
    bus_in = 8'h00; cmd_in = 1'b0; dat_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R2: plain forwarding, strobes and command bytes included
    step(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    step(8'h34, 1'b0, 1'b1, 1'b0, 1'b0, 2);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    command(8'h5A, 8'h80, 2);
    window(2, 1'b0, 2);

    // R5 R6 R3: read to own ID, source has 3 bytes for a 5-byte window
    load_src(3, 8'h90);
    command(8'h5A, 8'h30, 4);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5);
    window(5, 1'b1, 5);
    // R8: next window forwarded unchanged
    window(3, 1'b0, 8);

    // R7: read for another node
    load_src(4, 8'h40);
    command(8'h11, 8'h30, 7);
    window(3, 1'b0, 7);

    // R4: broadcast read
    command(8'hFF, 8'h30, 4);
    window(2, 1'b1, 4);

    // R10: accepted non-read opcode cancels armed read
    load_src(4, 8'h60);
    command(8'h5A, 8'h30, 10);
    command(8'h5A, 8'h85, 10);
    window(3, 1'b0, 10);

    // R9: suspend mid-window with armed read
    command(8'h5A, 8'h30, 9);
    step(8'hE0, 1'b0, 1'b1, 1'b0, 1'b1, 9);
    step(8'h77, 1'b1, 1'b0, 1'b1, 1'b0, 9);
    step(8'h66, 1'b0, 1'b1, 1'b1, 1'b0, 9);
    step(8'hE1, 1'b0, 1'b1, 1'b0, 1'b1, 9);
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 9);
    settle();

    checks++;
    if (takes !== exp_takes) begin
      errors++;
      $display("FAIL R5: got %0d read bytes taken expected %0d", takes, exp_takes);
    end

    // R1: reset cancels a pending read
    load_src(2, 8'hB0);
    command(8'h5A, 8'h30, 1);
    settle();
    @(negedge clk); rst_n = 1'b0;
    #1;
    checks++;
    if (bus_out !== 8'h00 || cmd_out !== 1'b0 || dat_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: got bus=%h cmd=%b dat=%b expected all zero", bus_out, cmd_out, dat_out);
    end
    @(negedge clk); rst_n = 1'b1;
    last = '0;
    exp_rd.delete();
    window(2, 1'b0, 1);
    settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule